// File: doc/BRIEF.md
# Carrier, Collision and Link Mode Controller

This block sits between the receive and transmit datapaths of a 100 Mb/s twisted-pair PHY and the MAC-facing media interface. From two activity flags in the 25 MHz interface clock domain it produces the carrier sense and collision outputs. The rules for both depend on whether the port is a station or a repeater port, on the duplex state, and on the loopback and collision-test controls.

The block also settles the link mode. With auto-negotiation on, it takes the negotiated result as an input. With auto-negotiation off, it resolves the mode from the speed bit, the duplex bit and a link-good flag from an external 100BASE-T4 transceiver. From the resolved mode it drives a duplex indicator and the disable outputs for the external 10BASE-T and 100BASE-T4 transceivers.

Top module: `link_sense_ctrl`

## Requirements
- R1: In station mode with a full-duplex mode resolved, `crs` is high one cycle after either `rx_active` or `tx_active` is high. It is low one cycle after both are low.
- R2: In repeater mode, or in any half-duplex mode (codes 0, 2, 4), `crs` follows `rx_active` only. Transmit activity alone leaves it low.
- R3: With `cfg_repeater` high, a full-duplex result is replaced by the matching half-duplex code: 1 becomes 0, and 3 becomes 2.
- R4: In a half-duplex mode, `col` is high one cycle after `rx_active` and `tx_active` are both high. It stays high for as long as the overlap lasts and drops one cycle after the overlap ends.
- R5: `col` is held low while `cfg_loopback` is high, and while a full-duplex mode (code 1 or 3) is resolved.
- R6: With auto-negotiation off and `cfg_speed100` high, a high `t4_link_ok` gives mode 4 whatever `cfg_full_duplex` is. Otherwise `cfg_full_duplex` selects 3 (high) or 2 (low).
- R7: With auto-negotiation off and `cfg_speed100` low, `cfg_full_duplex` selects 1 (high) or 0 (low), and `t4_link_ok` has no effect.
- R8: With `cfg_an_enable` high, the mode is the 3-bit `an_mode` input. Codes 5 to 7 resolve to 0, and R3 still applies.
- R9: `duplex_ind` is low after `an_reset`. It stays low until negotiation runs (`an_busy`) or auto-negotiation is turned off. It is high while `an_busy` is high, and otherwise follows the resolved mode (high for codes 1 and 3).
- R10: `ext10_off` is low in modes 0 and 1 and high in modes 2, 3 and 4. `ext_t4_off` is low in mode 4 only.
- R11: With `cfg_col_test` high in a half-duplex mode and loopback off, `col` follows `tx_active` with a one-cycle delay, and no receive activity is needed.
- R12: `mode` is registered. Its encoding is 0 = 10BASE-T half, 1 = 10BASE-T full, 2 = 100BASE-TX half, 3 = 100BASE-TX full, 4 = 100BASE-T4. It changes one cycle after its inputs change and is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_active | input | 1 | Receive non-idle activity |
| tx_active | input | 1 | Transmit activity (transmit enable) |
| cfg_repeater | input | 1 | Repeater-port strap |
| cfg_full_duplex | input | 1 | Control duplex bit |
| cfg_loopback | input | 1 | Loopback control |
| cfg_col_test | input | 1 | Collision test control |
| cfg_speed100 | input | 1 | Speed select, 1 = 100 Mb/s |
| cfg_an_enable | input | 1 | Auto-negotiation enable |
| t4_link_ok | input | 1 | External 100BASE-T4 link good |
| an_mode | input | 3 | Negotiated mode code |
| an_busy | input | 1 | Negotiation in progress |
| an_reset | input | 1 | Negotiation reset event |
| crs | output | 1 | Carrier sense |
| col | output | 1 | Collision |
| mode | output | 3 | Resolved mode code |
| duplex_ind | output | 1 | Duplex indicator |
| ext10_off | output | 1 | Disable for the external 10BASE-T transceiver |
| ext_t4_off | output | 1 | Disable for the external 100BASE-T4 transceiver |

## Verification
Carrier sense and collision are both decided in the same cycle from the same pair of activity flags. A simultaneous receive and transmit therefore has to raise both outputs in half duplex, and raise carrier sense while keeping collision low in full duplex or loopback. The bench sets up each mode, waits for the mode register to settle, and then drives overlapping activity. At the following falling edge it compares both outputs against values worked out from the mode rules, so one overlap judges both functions together.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    LM_10HD = 3'd0,
    LM_10FD = 3'd1,
    LM_TXHD = 3'd2,
    LM_TXFD = 3'd3,
    LM_T4   = 3'd4
  } link_mode_e;

  function automatic logic mode_full(input link_mode_e m);
    return (m == LM_10FD) || (m == LM_TXFD);
  endfunction
endpackage

// File: rtl/lsc_rst_sync.sv
module lsc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/lsc_mode_resolve.sv
module lsc_mode_resolve
  import lsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              an_enable,
  input  logic [MODE_W-1:0] an_mode,
  input  logic              speed100,
  input  logic              full_duplex,
  input  logic              t4_ok,
  input  logic              repeater,
  output link_mode_e        mode_q
);
  link_mode_e base_d, mode_d;
  logic       upd_en;

  always_comb begin
    if (an_enable) begin
      base_d = (an_mode <= MODE_W'(LM_T4)) ? link_mode_e'(an_mode) : LM_10HD;
    end else if (speed100) begin
      if (t4_ok)            base_d = LM_T4;
      else if (full_duplex) base_d = LM_TXFD;
      else                  base_d = LM_TXHD;
    end else begin
      base_d = full_duplex ? LM_10FD : LM_10HD;
    end
    mode_d = base_d;
    if (repeater) begin
      if (base_d == LM_10FD) mode_d = LM_10HD;
      if (base_d == LM_TXFD) mode_d = LM_TXHD;
    end
  end

  assign upd_en = (mode_d != mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mode_q <= LM_10HD;
    else if (upd_en) mode_q <= mode_d;
  end
endmodule

// File: rtl/lsc_activity.sv
module lsc_activity
  import lsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_act,
  input  logic       tx_act,
  input  logic       repeater,
  input  logic       loopback,
  input  logic       col_test,
  input  link_mode_e mode,
  output logic       crs_q,
  output logic       col_q
);
  logic full, crs_d, col_d;

  always_comb begin
    full  = mode_full(mode);
    crs_d = rx_act | (tx_act & ~repeater & full);
    if (loopback || full) col_d = 1'b0;
    else if (col_test)    col_d = tx_act;
    else                  col_d = rx_act & tx_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crs_q <= 1'b0;
      col_q <= 1'b0;
    end else begin
      crs_q <= crs_d;
      col_q <= col_d;
    end
  end
endmodule

// File: rtl/lsc_duplex_ind.sv
module lsc_duplex_ind
  import lsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       an_enable,
  input  logic       an_busy,
  input  logic       an_reset,
  input  link_mode_e mode,
  output logic       dup_q
);
  logic held_q, held_d, dup_d;

  always_comb begin
    if (an_reset)                   held_d = 1'b1;
    else if (an_busy || !an_enable) held_d = 1'b0;
    else                            held_d = held_q;

    if (an_reset)     dup_d = 1'b0;
    else if (an_busy) dup_d = 1'b1;
    else if (held_q)  dup_d = 1'b0;
    else              dup_d = mode_full(mode);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      dup_q  <= 1'b0;
    end else begin
      held_q <= held_d;
      dup_q  <= dup_d;
    end
  end
endmodule

// File: rtl/link_sense_ctrl.sv
module link_sense_ctrl
  import lsc_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_active,
  input  logic              tx_active,
  input  logic              cfg_repeater,
  input  logic              cfg_full_duplex,
  input  logic              cfg_loopback,
  input  logic              cfg_col_test,
  input  logic              cfg_speed100,
  input  logic              cfg_an_enable,
  input  logic              t4_link_ok,
  input  logic [MODE_W-1:0] an_mode,
  input  logic              an_busy,
  input  logic              an_reset,
  output logic              crs,
  output logic              col,
  output logic [MODE_W-1:0] mode,
  output logic              duplex_ind,
  output logic              ext10_off,
  output logic              ext_t4_off
);
  logic       rst_i_n;
  link_mode_e mode_q;

  lsc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  lsc_mode_resolve u_mode (
    .clk(clk), .rst_n(rst_i_n), .an_enable(cfg_an_enable), .an_mode(an_mode),
    .speed100(cfg_speed100), .full_duplex(cfg_full_duplex), .t4_ok(t4_link_ok),
    .repeater(cfg_repeater), .mode_q(mode_q)
  );

  lsc_activity u_act (
    .clk(clk), .rst_n(rst_i_n), .rx_act(rx_active), .tx_act(tx_active),
    .repeater(cfg_repeater), .loopback(cfg_loopback), .col_test(cfg_col_test),
    .mode(mode_q), .crs_q(crs), .col_q(col)
  );

  lsc_duplex_ind u_dup (
    .clk(clk), .rst_n(rst_i_n), .an_enable(cfg_an_enable), .an_busy(an_busy),
    .an_reset(an_reset), .mode(mode_q), .dup_q(duplex_ind)
  );

  assign mode       = mode_q;
  assign ext10_off  = (mode_q != LM_10HD) && (mode_q != LM_10FD);
  assign ext_t4_off = (mode_q != LM_T4);
endmodule

// File: rtl/link_sense_ctrl_chk.sv
module link_sense_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_active,
  input logic       tx_active,
  input logic       cfg_repeater,
  input logic       cfg_loopback,
  input logic       an_busy,
  input logic       an_reset,
  input logic       crs,
  input logic       col,
  input logic [2:0] mode,
  input logic       duplex_ind
);
  logic fd;
  assign fd = (mode == 3'd1) || (mode == 3'd3);

  AST_CRS_ON_RX: assert property (@(posedge clk) disable iff (!rst_n)
    rx_active |=> crs);                                             // R1
  AST_CRS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_active && !tx_active) |=> !crs);                           // R1
  AST_CRS_STATION_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && !cfg_repeater && fd) |=> crs);                    // R1
  AST_CRS_RX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_repeater || !fd) && !rx_active) |=> !crs);                // R2
  AST_REP_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_repeater |=> (mode != 3'd1 && mode != 3'd3));               // R3
  AST_COL_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_active && tx_active && !cfg_loopback && !fd) |=> col);      // R4
  AST_COL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_loopback || fd) |=> !col);                                 // R5
  AST_DUP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (an_busy && !an_reset) |=> duplex_ind);                         // R9
  AST_DUP_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    an_reset |=> !duplex_ind);                                      // R9
  AST_MODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mode <= 3'd4);                                                  // R12
endmodule

bind link_sense_ctrl link_sense_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_i_n), .rx_active(rx_active), .tx_active(tx_active),
  .cfg_repeater(cfg_repeater), .cfg_loopback(cfg_loopback), .an_busy(an_busy),
  .an_reset(an_reset), .crs(crs), .col(col), .mode(mode), .duplex_ind(duplex_ind)
);

// File: tb/sim_link_sense_ctrl.sv
module sim_link_sense_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_active, tx_active, cfg_repeater, cfg_full_duplex, cfg_loopback;
  logic       cfg_col_test, cfg_speed100, cfg_an_enable, t4_link_ok, an_busy, an_reset;
  logic [2:0] an_mode, mode;
  logic       crs, col, duplex_ind, ext10_off, ext_t4_off;
  int         total = 0;
  int         bad = 0;

  always #5 clk = ~clk;

  link_sense_ctrl u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input logic an, input logic sp, input logic fdx,
                         input logic t4, input logic rep, input logic lb);
    cfg_an_enable = an; cfg_speed100 = sp; cfg_full_duplex = fdx;
    t4_link_ok = t4; cfg_repeater = rep; cfg_loopback = lb;
    rx_active = 0; tx_active = 0;
    step(3);
  endtask

  task automatic act(input logic rx, input logic tx);
    rx_active = rx; tx_active = tx;
    step(1);
  endtask

  task automatic t_reset;
    rst_n = 0; rx_active = 0; tx_active = 0; cfg_repeater = 0; cfg_full_duplex = 0;
    cfg_loopback = 0; cfg_col_test = 0; cfg_speed100 = 0; cfg_an_enable = 0;
    t4_link_ok = 0; an_mode = 0; an_busy = 0; an_reset = 0;
    step(3);
    chk("R12 reset mode", mode, 0);
    chk("R1 reset crs", crs, 0);
    chk("R4 reset col", col, 0);
    rst_n = 1;
    step(4);
  endtask

  task automatic t_forced;
    cfg_speed100 = 1; cfg_full_duplex = 1; step(1);
    chk("R12 one-cycle mode update", mode, 3);
    set_cfg(0, 1, 1, 0, 0, 0); chk("R6 TX full", mode, 3);
    set_cfg(0, 1, 0, 0, 0, 0); chk("R6 TX half", mode, 2);
    set_cfg(0, 1, 1, 1, 0, 0); chk("R6 T4 over duplex", mode, 4);
    set_cfg(0, 0, 1, 1, 0, 0); chk("R7 10 full t4 ignored", mode, 1);
    set_cfg(0, 0, 0, 1, 0, 0); chk("R7 10 half t4 ignored", mode, 0);
  endtask

  task automatic t_an;
    an_mode = 3; set_cfg(1, 0, 0, 0, 0, 0); chk("R8 negotiated 3", mode, 3);
    an_mode = 4; step(2); chk("R8 negotiated 4", mode, 4);
    an_mode = 6; step(2); chk("R8 invalid code", mode, 0);
    an_mode = 3; set_cfg(1, 0, 0, 0, 1, 0); chk("R3 R8 repeater halves", mode, 2);
    set_cfg(0, 0, 1, 0, 1, 0); chk("R3 repeater 10 full", mode, 0);
  endtask

  task automatic t_crs_col;
    set_cfg(0, 1, 1, 0, 0, 0);
    act(0, 1); chk("R1 station tx crs", crs, 1); chk("R5 fd col", col, 0);
    act(1, 1); chk("R1 overlap crs", crs, 1); chk("R5 fd overlap col", col, 0);
    act(0, 0); chk("R1 idle crs", crs, 0);
    set_cfg(0, 1, 0, 0, 0, 0);
    act(0, 1); chk("R2 half tx crs", crs, 0); chk("R4 tx only col", col, 0);
    act(1, 1); chk("R4 overlap col", col, 1); chk("R2 overlap crs", crs, 1);
    act(1, 1); chk("R4 overlap held", col, 1);
    act(1, 0); chk("R4 overlap end", col, 0); chk("R2 rx crs", crs, 1);
    set_cfg(0, 1, 1, 0, 1, 0);
    act(0, 1); chk("R2 repeater tx crs", crs, 0);
    set_cfg(0, 1, 0, 0, 0, 1);
    act(1, 1); chk("R5 loopback col", col, 0);
    act(0, 0);
  endtask

  task automatic t_col_test;
    set_cfg(0, 0, 0, 0, 0, 0);
    cfg_col_test = 1;
    act(0, 1); chk("R11 coltest col", col, 1);
    act(0, 0); chk("R11 coltest release", col, 0);
    set_cfg(0, 0, 1, 0, 0, 0);
    act(0, 1); chk("R5 R11 fd coltest", col, 0);
    cfg_col_test = 0; act(0, 0);
  endtask

  task automatic t_duplex;
    an_mode = 3; set_cfg(1, 0, 0, 0, 0, 0);
    chk("R9 follows fd", duplex_ind, 1);
    an_reset = 1; step(1); chk("R9 reset low", duplex_ind, 0);
    an_reset = 0; step(3); chk("R9 held low", duplex_ind, 0);
    an_busy = 1; step(1); chk("R9 busy high", duplex_ind, 1);
    an_mode = 2; an_busy = 0; step(3); chk("R9 follows hd", duplex_ind, 0);
  endtask

  task automatic t_ext;
    set_cfg(0, 0, 1, 0, 0, 0);
    chk("R10 10fd ext10", ext10_off, 0); chk("R10 10fd t4", ext_t4_off, 1);
    set_cfg(0, 1, 0, 0, 0, 0);
    chk("R10 tx ext10", ext10_off, 1); chk("R10 tx t4", ext_t4_off, 1);
    set_cfg(0, 1, 0, 1, 0, 0);
    chk("R10 t4 ext10", ext10_off, 1); chk("R10 t4 t4", ext_t4_off, 0);
  endtask

  initial begin
    #2_000_000;
    chk("watchdog", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_forced();
    t_an();
    t_crs_col();
    t_col_test();
    t_duplex();
    t_ext();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule